// File: doc/BRIEF.md
# MESI snooping cache controller

This block keeps a small direct-mapped, write-back data cache coherent with its peers on a shared snooping bus. Each line is in one of four states: Modified (dirty, only copy), Exclusive (clean, only copy), Shared (clean, possibly held elsewhere) or Invalid. The processor side issues single-word reads and writes. The block answers hits locally. It drives a bus request for misses, for writes to Shared lines and for dirty victims. At the same time it watches the transactions that other caches win on the bus and updates its own copies to match.

A bus transaction completes in the cycle it is granted. The peers' snoop answers (a shared flag, a dirty flag and supplied data) arrive in that same cycle. The memory side picks up supplied dirty data as a write-back. The line state machine has two states. In Idle it accepts a request. Read hits, writes to Modified lines and silent Exclusive-to-Modified upgrades all complete from Idle. Misses and writes to Shared lines go to Bus. In Bus the command is re-derived every cycle from the current line state. A dirty victim is written back first, and the block stays in Bus after that grant. Bus moves back to Idle on the grant of the fill or upgrade.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high and `bus_req` is low, so the first access to any address goes to the bus.
- R2: A read miss requests bus command 0 (read line) and returns the bus data. The line fills as Exclusive when `bus_shared_in` is low and as Shared when it is high.
- R3: A read hit returns the cached word with no bus transaction.
- R4: A write to an Exclusive or Modified line completes with no bus transaction and leaves the line Modified.
- R5: A write miss requests bus command 1 (read-and-invalidate) and leaves the line Modified, holding the written word.
- R6: A write to a Shared line requests bus command 2 (invalidate, address only) and leaves the line Modified.
- R7: A snooped command 0 that hits a valid line raises `snp_shared`. A Modified line also raises `snp_dirty`, drives its word on `snp_data` and becomes Shared. An Exclusive line becomes Shared.
- R8: A snooped command 1 or 2 that hits a valid line makes it Invalid. A Modified line raises `snp_dirty` and supplies its word first.
- R9: A miss whose victim is Modified first requests command 3 (write line) with the victim's address and word, then the fill. A clean victim is dropped with no write.
- R10: The bus command is chosen from the line state in the grant cycle. A Shared line that a peer invalidates while this block waits to upgrade it is requested again with command 1.
- R11: A request is taken only in a cycle where `cpu_ready` is high. `cpu_ready` is low while a request is in flight and during any cycle in which a peer's transaction is being snooped. `cpu_done` is high for one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, taken when cpu_ready is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Block can take a request this cycle |
| cpu_done | output | 1 | Request finished (one cycle) |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 0 read line, 1 read-and-invalidate, 2 invalidate, 3 write line |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-line word |
| bus_gnt | input | 1 | Grant; transaction completes this cycle |
| bus_rdata | input | DATA_W | Fill word (peer-supplied or memory) |
| bus_shared_in | input | 1 | A peer holds the requested line |
| snp_valid | input | 1 | A peer's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_dirty | output | 1 | This cache supplies dirty data |
| snp_data | output | DATA_W | Supplied word |

## Verification
Two controllers share a bench memory. The bench counts each controller's granted commands per operation, so missing or extra traffic shows up at once. A design that filled a read as Shared with no sharer would send an invalidate where a silent upgrade was due. One that ignored a peer's dirty copy would return stale memory data. A controller that skipped the victim write-back, or wrote back clean victims, changes the command count and the later read values. Two writes to the same Shared word, issued in the same cycle, check that the loser re-derives its command after its copy is invalidated and does not send a bare invalidate. A long pseudo-random sweep of reads and writes from both caches is then checked against a sequential memory model.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        BC_RD    = 2'd0,
        BC_RDINV = 2'd1,
        BC_INV   = 2'd2,
        BC_WR    = 2'd3
    } bus_cmd_t;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_BUS  = 1'b1
    } fsm_st_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_t          a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_t          b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  line_st_t          wa_state,
    input  logic [TAG_W-1:0]  wa_tag,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  line_st_t          wb_state
);
    line_st_t          st_q   [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            if (!rst_n) begin
                st_q[s]   <= LS_I;
                tag_q[s]  <= '0;
                data_q[s] <= '0;
            end else if (wb_en && wb_idx == IDX_W'(s)) begin
                st_q[s] <= wb_state;
            end else if (wa_en && wa_idx == IDX_W'(s)) begin
                st_q[s]   <= wa_state;
                tag_q[s]  <= wa_tag;
                data_q[s] <= wa_data;
            end
        end
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = data_q[b_idx];

    // R11: requester and snooper never update the array in the same cycle
    a_r11_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(wa_en && wb_en));
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  bus_cmd_t          snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_t          b_state,
    input  logic [TAG_W-1:0]  b_tag,
    input  logic [DATA_W-1:0] b_data,
    output logic              snp_shared,
    output logic              snp_dirty,
    output logic [DATA_W-1:0] snp_data,
    output logic              wb_en,
    output line_st_t          wb_state
);
    logic hold;

    assign hold = snp_valid && (b_state != LS_I) && (b_tag == snp_tag) && (snp_cmd != BC_WR);

    always_comb begin
        snp_shared = hold;
        snp_dirty  = hold && (b_state == LS_M);
        snp_data   = snp_dirty ? b_data : '0;
        wb_en      = 1'b0;
        wb_state   = LS_I;
        if (hold) begin
            unique case (snp_cmd)
                BC_RD: begin
                    wb_en    = (b_state != LS_S);
                    wb_state = LS_S;
                end
                BC_RDINV, BC_INV: begin
                    wb_en    = 1'b1;
                    wb_state = LS_I;
                end
                default: begin
                    wb_en    = 1'b0;
                    wb_state = LS_I;
                end
            endcase
        end
    end

    // R8: a supplied dirty word always comes with the shared flag
    a_r8_dirty_with_shared: assert property (@(posedge clk) disable iff (!rst_n)
        snp_dirty |-> snp_shared);
    // R7: nothing answers a snooped write line
    a_r7_no_answer_to_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == BC_WR) |-> !wb_en);
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req,
    input  logic                      cpu_we,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    output logic                      cpu_ready,
    output logic                      cpu_done,
    output logic [DATA_W-1:0]         cpu_rdata,
    input  logic                      snp_valid,
    output logic                      bus_req,
    output bus_cmd_t                  bus_cmd,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic [DATA_W-1:0]         bus_wdata,
    input  logic                      bus_gnt,
    input  logic [DATA_W-1:0]         bus_rdata,
    input  logic                      bus_shared_in,
    output logic [IDX_W-1:0]          a_idx,
    input  line_st_t                  a_state,
    input  logic [ADDR_W-IDX_W-1:0]   a_tag,
    input  logic [DATA_W-1:0]         a_data,
    output logic                      wa_en,
    output logic [IDX_W-1:0]          wa_idx,
    output line_st_t                  wa_state,
    output logic [ADDR_W-IDX_W-1:0]   wa_tag,
    output logic [DATA_W-1:0]         wa_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    fsm_st_t           fs_q, fs_d;
    logic              op_we;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_wdata;
    logic              done_d;
    logic [DATA_W-1:0] rdata_d;
    logic [ADDR_W-1:0] look_addr;
    logic [TAG_W-1:0]  look_tag;
    logic              hit;
    logic              accept;

    assign look_addr = (fs_q == FS_IDLE) ? cpu_addr : op_addr;
    assign a_idx     = look_addr[IDX_W-1:0];
    assign look_tag  = look_addr[ADDR_W-1:IDX_W];
    assign hit       = (a_state != LS_I) && (a_tag == look_tag);
    assign cpu_ready = (fs_q == FS_IDLE) && !snp_valid;
    assign accept    = cpu_req && cpu_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q      <= FS_IDLE;
            op_we     <= 1'b0;
            op_addr   <= '0;
            op_wdata  <= '0;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            fs_q      <= fs_d;
            cpu_done  <= done_d;
            cpu_rdata <= rdata_d;
            if (accept) begin
                op_we    <= cpu_we;
                op_addr  <= cpu_addr;
                op_wdata <= cpu_wdata;
            end
        end
    end

    always_comb begin
        fs_d      = fs_q;
        done_d    = 1'b0;
        rdata_d   = cpu_rdata;
        bus_req   = 1'b0;
        bus_cmd   = BC_RD;
        bus_addr  = op_addr;
        bus_wdata = op_wdata;
        wa_en     = 1'b0;
        wa_idx    = a_idx;
        wa_state  = a_state;
        wa_tag    = look_tag;
        wa_data   = a_data;
        unique case (fs_q)
            FS_IDLE: begin
                if (accept) begin
                    if (hit && !cpu_we) begin
                        done_d  = 1'b1;
                        rdata_d = a_data;
                    end else if (hit && (a_state == LS_M || a_state == LS_E)) begin
                        wa_en    = 1'b1;
                        wa_state = LS_M;
                        wa_data  = cpu_wdata;
                        done_d   = 1'b1;
                    end else begin
                        fs_d = FS_BUS;
                    end
                end
            end
            FS_BUS: begin
                bus_req = 1'b1;
                if (a_state == LS_M && !hit) begin
                    bus_cmd   = BC_WR;
                    bus_addr  = {a_tag, a_idx};
                    bus_wdata = a_data;
                    if (bus_gnt) begin
                        wa_en    = 1'b1;
                        wa_state = LS_I;
                        wa_tag   = a_tag;
                    end
                end else if (op_we && hit) begin
                    bus_cmd = BC_INV;
                    if (bus_gnt) begin
                        wa_en    = 1'b1;
                        wa_state = LS_M;
                        wa_data  = op_wdata;
                        done_d   = 1'b1;
                        fs_d     = FS_IDLE;
                    end
                end else if (op_we) begin
                    bus_cmd = BC_RDINV;
                    if (bus_gnt) begin
                        wa_en    = 1'b1;
                        wa_state = LS_M;
                        wa_data  = op_wdata;
                        done_d   = 1'b1;
                        fs_d     = FS_IDLE;
                    end
                end else begin
                    bus_cmd = BC_RD;
                    if (bus_gnt) begin
                        wa_en    = 1'b1;
                        wa_state = bus_shared_in ? LS_S : LS_E;
                        wa_data  = bus_rdata;
                        done_d   = 1'b1;
                        rdata_d  = bus_rdata;
                        fs_d     = FS_IDLE;
                    end
                end
            end
            default: fs_d = FS_IDLE;
        endcase
    end

    // R10: a pending request stays asserted until it is granted
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);
    // R9: a victim write-back is followed by a fill, never a second write-back
    a_r9_fill_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && bus_cmd == BC_WR) |=> (bus_req && bus_cmd != BC_WR));
    // R5: a granted fill or upgrade finishes the request on the next cycle
    a_r5_done_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && bus_cmd != BC_WR) |=> cpu_done);
    // R11: no new request is taken while the bus is requested
    a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !bus_req);
endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int SETS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_dirty,
    output logic [DATA_W-1:0] snp_data
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  a_idx;
    line_st_t          a_state, b_state;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;
    logic              wa_en, wb_en;
    logic [IDX_W-1:0]  wa_idx;
    line_st_t          wa_state, wb_state;
    logic [TAG_W-1:0]  wa_tag;
    logic [DATA_W-1:0] wa_data;
    bus_cmd_t          cmd_w;

    mesi_line_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
        .b_idx(snp_addr[IDX_W-1:0]), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_state(wa_state), .wa_tag(wa_tag), .wa_data(wa_data),
        .wb_en(wb_en), .wb_idx(snp_addr[IDX_W-1:0]), .wb_state(wb_state)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_cmd(bus_cmd_t'(snp_cmd)),
        .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
        .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
        .snp_shared(snp_shared), .snp_dirty(snp_dirty), .snp_data(snp_data),
        .wb_en(wb_en), .wb_state(wb_state)
    );

    mesi_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .snp_valid(snp_valid),
        .bus_req(bus_req), .bus_cmd(cmd_w), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
        .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_state(wa_state), .wa_tag(wa_tag), .wa_data(wa_data)
    );

    assign bus_cmd = cmd_w;

    // R1: no bus request in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !bus_req);
endmodule

// File: tb/mesi_cache_ctrl_bench.sv
module mesi_cache_ctrl_bench;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          c_req   [2];
    logic          c_we    [2];
    logic [AW-1:0] c_addr  [2];
    logic [DW-1:0] c_wdata [2];

    logic          ready0, ready1, done0, done1;
    logic [DW-1:0] rdata0, rdata1;
    logic          breq0, breq1, gnt0, gnt1;
    logic [1:0]    bcmd0, bcmd1;
    logic [AW-1:0] baddr0, baddr1;
    logic [DW-1:0] bwd0, bwd1, brd0, brd1;
    logic          shr0, shr1, dty0, dty1;
    logic [DW-1:0] sdat0, sdat1;
    logic [DW-1:0] mem [NW];

    assign gnt0 = breq0;
    assign gnt1 = breq1 & ~breq0;
    assign brd0 = dty1 ? sdat1 : mem[baddr0];
    assign brd1 = dty0 ? sdat0 : mem[baddr1];

    mesi_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETS(4)) u_mesi_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(c_req[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]), .cpu_wdata(c_wdata[0]),
        .cpu_ready(ready0), .cpu_done(done0), .cpu_rdata(rdata0),
        .bus_req(breq0), .bus_cmd(bcmd0), .bus_addr(baddr0), .bus_wdata(bwd0),
        .bus_gnt(gnt0), .bus_rdata(brd0), .bus_shared_in(shr1),
        .snp_valid(gnt1), .snp_cmd(bcmd1), .snp_addr(baddr1),
        .snp_shared(shr0), .snp_dirty(dty0), .snp_data(sdat0)
    );

    mesi_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETS(4)) u_mesi_cache_ctrl_peer (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(c_req[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]), .cpu_wdata(c_wdata[1]),
        .cpu_ready(ready1), .cpu_done(done1), .cpu_rdata(rdata1),
        .bus_req(breq1), .bus_cmd(bcmd1), .bus_addr(baddr1), .bus_wdata(bwd1),
        .bus_gnt(gnt1), .bus_rdata(brd1), .bus_shared_in(shr0),
        .snp_valid(gnt0), .snp_cmd(bcmd0), .snp_addr(baddr0),
        .snp_shared(shr1), .snp_dirty(dty1), .snp_data(sdat1)
    );

    function automatic logic [DW-1:0] init_word(input int a);
        return DW'(a * 7 + 3);
    endfunction

    // shared memory: write-line stores, supplied dirty data is written back
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mem[i] <= init_word(i);
        end else if (gnt0) begin
            if (bcmd0 == 2'd3) mem[baddr0] <= bwd0;
            else if (dty1) mem[baddr0] <= sdat1;
        end else if (gnt1) begin
            if (bcmd1 == 2'd3) mem[baddr1] <= bwd1;
            else if (dty0) mem[baddr1] <= sdat0;
        end
    end

    int n_cmd [2][4];
    int n_sup [2];
    logic [1:0] last_cmd0, prev_cmd0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (gnt0) begin n_cmd[0][bcmd0]++; prev_cmd0 <= last_cmd0; last_cmd0 <= bcmd0; end
            if (gnt1) n_cmd[1][bcmd1]++;
            if (gnt1 && dty0) n_sup[0]++;
            if (gnt0 && dty1) n_sup[1]++;
        end
    end

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [DW-1:0] ref_mem [NW];
    int base [2][4];

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic snap(input int c);
        for (int k = 0; k < 4; k++) base[c][k] = n_cmd[c][k];
    endtask

    // traffic code: reads + 10*read-inval + 100*inval + 1000*write-line
    task automatic traffic(input int c, input string tag, input int exp);
        int t;
        t = (n_cmd[c][0] - base[c][0]) + 10 * (n_cmd[c][1] - base[c][1])
          + 100 * (n_cmd[c][2] - base[c][2]) + 1000 * (n_cmd[c][3] - base[c][3]);
        chk(tag, t, exp);
    endtask

    task automatic do_op(input int c, input logic we, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, output logic [DW-1:0] rd);
        @(negedge clk);
        c_we[c] = we; c_addr[c] = a; c_wdata[c] = wd;
        while (!((c == 0) ? ready0 : ready1)) @(negedge clk);
        c_req[c] = 1'b1;
        @(negedge clk);
        c_req[c] = 1'b0;
        while (!((c == 0) ? done0 : done1)) @(negedge clk);
        rd = (c == 0) ? rdata0 : rdata1;
    endtask

    task automatic rd_chk(input int c, input logic [AW-1:0] a, input string tag);
        logic [DW-1:0] r;
        do_op(c, 1'b0, a, '0, r);
        chk(tag, int'(r), int'(ref_mem[a]));
    endtask

    task automatic wr(input int c, input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] r;
        do_op(c, 1'b1, a, d, r);
        ref_mem[a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        int s0;
        for (int i = 0; i < NW; i++) ref_mem[i] = init_word(i);
        for (int c = 0; c < 2; c++) begin
            c_req[c] = 1'b0; c_we[c] = 1'b0; c_addr[c] = '0; c_wdata[c] = '0;
            n_sup[c] = 0;
            for (int k = 0; k < 4; k++) n_cmd[c][k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", int'(ready0 & ready1), 1);
        chk("R1 no bus request after reset", int'(breq0 | breq1), 0);

        // read miss, no sharer -> Exclusive
        snap(0); rd_chk(0, 6'd5, "R2 read miss data"); traffic(0, "R1 R2 read miss traffic", 1);
        snap(0); rd_chk(0, 6'd5, "R3 read hit data"); traffic(0, "R3 read hit traffic", 0);
        @(negedge clk); chk("R11 done is one cycle", int'(done0), 0);
        snap(0); wr(0, 6'd5, 8'hA1); traffic(0, "R4 silent upgrade traffic", 0);

        // peer read of a Modified line
        snap(0); snap(1); s0 = n_sup[0];
        rd_chk(1, 6'd5, "R7 dirty supply data");
        traffic(1, "R7 peer read traffic", 1);
        traffic(0, "R7 owner quiet", 0);
        chk("R7 owner supplied", n_sup[0] - s0, 1);
        snap(0); rd_chk(0, 6'd5, "R7 owner now shared hit"); traffic(0, "R7 shared hit traffic", 0);

        // write to Shared line -> invalidate
        snap(1); wr(1, 6'd5, 8'hB2); traffic(1, "R6 shared write traffic", 100);
        snap(0); s0 = n_sup[1];
        rd_chk(0, 6'd5, "R8 invalidated copy refetch");
        traffic(0, "R8 refetch traffic", 1);
        chk("R8 peer supplied", n_sup[1] - s0, 1);
        snap(0); wr(0, 6'd5, 8'hC3); traffic(0, "R2 shared fill then invalidate", 100);
        rd_chk(1, 6'd5, "R7 read after upgrade");

        // write misses
        snap(0); wr(0, 6'd15, 8'h44); traffic(0, "R5 write miss traffic", 10);
        snap(1); s0 = n_sup[0]; wr(1, 6'd15, 8'h55);
        traffic(1, "R5 peer write miss traffic", 10);
        chk("R8 modified supplied on read-inval", n_sup[0] - s0, 1);
        snap(0); rd_chk(0, 6'd15, "R8 read after read-inval"); traffic(0, "R8 reread traffic", 1);

        // eviction
        snap(0); wr(0, 6'd4, 8'h66); traffic(0, "R5 write miss set0", 10);
        snap(0); rd_chk(0, 6'd8, "R9 fill after write-back");
        traffic(0, "R9 dirty victim traffic", 1001);
        chk("R9 write-back precedes fill", int'({prev_cmd0, last_cmd0}), 12);
        s0 = n_sup[0];
        rd_chk(1, 6'd4, "R9 written-back word in memory");
        chk("R9 no supply after eviction", n_sup[0] - s0, 0);
        snap(0); rd_chk(0, 6'd4, "R9 clean victim refill"); traffic(0, "R9 clean victim traffic", 1);

        // simultaneous writes to one Shared word
        rd_chk(0, 6'd7, "R2 fill D");
        rd_chk(1, 6'd7, "R2 share D");
        snap(0); snap(1);
        fork
            wr(0, 6'd7, 8'h77);
            begin
                logic [DW-1:0] r1;
                do_op(1, 1'b1, 6'd7, 8'h88, r1);
            end
        join
        ref_mem[7] = 8'h88;
        traffic(0, "R10 winner invalidates", 100);
        traffic(1, "R10 loser re-derives read-inval", 10);
        rd_chk(0, 6'd7, "R10 final value");

        // ready low while snooping
        fork
            rd_chk(0, 6'd12, "R2 fill set0");
            begin
                @(negedge clk);
                while (!gnt0) @(negedge clk);
                chk("R11 ready low during snoop", int'(ready1), 0);
            end
        join

        // pseudo-random sweep
        lf = 16'hACE1;
        for (int n = 0; n < 1500; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[1]) wr(int'(lf[0]), {2'b00, lf[5:2]}, lf[15:8]);
            else rd_chk(int'(lf[0]), {2'b00, lf[5:2]}, "R8 sweep coherence");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule